// File: doc/BRIEF.md
# Tree-instruction multiway branch selector

This block picks the next long instruction word on every clock cycle. A tree-structured instruction describes up to eight exit paths. Each path carries a three-valued condition pattern over the condition-code bits, a target instruction address, and a mask of the operation slots that are committed when that path is the one taken. The selector tests every path against the current condition codes in parallel. It registers the target and commit mask of the single matching path, so the fetch stage can issue a new branch each cycle without stall cycles.

The condition codes that compares write in one cycle are consumed here in the next cycle. The chosen word then executes one cycle later. Each path's pattern is split into two vectors. A care bit of 1 means the code is tested. The value bit at the same position gives the polarity the code must have. A path with no care bits set is an unconditional exit. A well-formed tree has mutually exclusive paths. When the inputs break that rule, because no path or several paths match, the block raises an error flag and falls back to path 0.

Top module: `mbr_tree_sel`

## Requirements
- R1: While `rst` is high at a rising edge, the next edge leaves `next_pc_o` = RESET_PC (default 0), `commit_o` = 0 and `err_o` = 0.
- R2: Path p occupies bits [p*8 +: 8] of `care_i` and `value_i`. It matches when its bit in `path_used_i` is 1 and ((cc XOR value) AND care) is zero, so codes whose care bit is 0 do not affect the result.
- R3: When exactly one path matches and `valid_i`=1, `stall_i`=0 at an edge, then after that edge `next_pc_o` shows that path's target (bits [p*16 +: 16] of `target_i`), `commit_o` shows its commit mask (bits [p*12 +: 12] of `commit_i`; bits 0..7 are ALU slots and bits 8..11 are memory slots), and `err_o` = 0.
- R4: A used path whose care vector is all zeros matches for every condition-code value.
- R5: A path whose `path_used_i` bit is 0 never matches, whatever its masks are.
- R6: When no path matches, `err_o` = 1 and the outputs take path 0's target and commit mask.
- R7: When two or more paths match, `err_o` = 1 and the outputs take path 0's target and commit mask.
- R8: While `stall_i` is high at an edge, all outputs keep their values and the inputs have no effect.
- R9: With `valid_i` = 0 and `stall_i` = 0 at an edge, `commit_o` and `err_o` become 0 and `next_pc_o` keeps its value.
- R10: A new selection is made at every edge with `valid_i`=1 and `stall_i`=0. Back-to-back instructions each produce their result after the very next edge, with no bubble cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | A tree instruction is present this cycle |
| stall_i | input | 1 | Hold all outputs |
| cc_i | input | 8 | Condition-code vector |
| path_used_i | input | 8 | Path p is part of the tree |
| care_i | input | 64 | Per-path tested-code masks |
| value_i | input | 64 | Per-path required code polarities |
| target_i | input | 128 | Per-path target addresses |
| commit_i | input | 96 | Per-path operation commit masks |
| next_pc_o | output | 16 | Registered next fetch address |
| commit_o | output | 12 | Registered commit mask of the taken path |
| err_o | output | 1 | Registered no-match or multi-match flag |

## Verification
The bench builds the block with its default parameters: eight condition codes, eight paths, 16-bit targets, and eight ALU slots plus four memory slots. With these values every path index and every bit of the care vector are reachable by random trees. The random trees have exactly one winning path, so each path in turn becomes the selected one. The directed cases place the unconditional and unused paths at interior positions, and they force empty and doubly-matching trees to show the fallback to path 0.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    parameter int unsigned CC_BITS   = 8;
    parameter int unsigned MAX_PATHS = 8;
    parameter int unsigned PC_BITS   = 16;
    parameter int unsigned ALU_SLOTS = 8;
    parameter int unsigned MEM_SLOTS = 4;
    localparam int unsigned SLOT_BITS = ALU_SLOTS + MEM_SLOTS;

    // outcome of scanning the path hit vector
    typedef enum logic [1:0] {
        PICK_ONE   = 2'd0,
        PICK_NONE  = 2'd1,
        PICK_MULTI = 2'd2
    } pick_e;

    function automatic pick_e classify(input int unsigned hits);
        if (hits == 1)      return PICK_ONE;
        else if (hits == 0) return PICK_NONE;
        else                return PICK_MULTI;
    endfunction

endpackage

// File: rtl/mbr_path_match.sv
module mbr_path_match #(
    parameter int unsigned CC_W = 8
) (
    input  logic [CC_W-1:0] cc,
    input  logic [CC_W-1:0] care,
    input  logic [CC_W-1:0] value,
    input  logic            used,
    output logic            hit
);
    logic [CC_W-1:0] mismatch;

    always_comb begin
        mismatch = (cc ^ value) & care;
        hit      = used && (mismatch == '0);
    end
endmodule

// File: rtl/mbr_path_pick.sv
module mbr_path_pick
    import mbr_pkg::*;
#(
    parameter int unsigned NP    = 8,
    parameter int unsigned IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0]    hit,
    output logic [IDX_W-1:0] sel,
    output pick_e            status
);
    localparam int unsigned CNT_W = $clog2(NP + 1);

    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;

    always_comb begin
        cnt = '0;
        idx = '0;
        for (int p = 0; p < NP; p++) begin
            if (hit[p]) begin
                cnt = cnt + CNT_W'(1);
                idx = idx | IDX_W'(p);
            end
        end
        status = classify(int'(cnt));
        sel    = (status == PICK_ONE) ? idx : '0;
    end
endmodule

// File: rtl/mbr_out_reg.sv
module mbr_out_reg
    import mbr_pkg::*;
#(
    parameter int unsigned PC_W     = 16,
    parameter int unsigned SLOT_W   = 12,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              stall,
    input  pick_e             status,
    input  logic [PC_W-1:0]   target,
    input  logic [SLOT_W-1:0] commit,
    output logic [PC_W-1:0]   pc_q,
    output logic [SLOT_W-1:0] commit_q,
    output logic              err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_PC;
            commit_q <= '0;
            err_q    <= 1'b0;
        end else if (!stall) begin
            if (valid) begin
                pc_q     <= target;
                commit_q <= commit;
                err_q    <= (status != PICK_ONE);
            end else begin
                commit_q <= '0;
                err_q    <= 1'b0;
            end
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pc_q) && $stable(commit_q) && $stable(err_q)));

    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid && !stall) |=> (commit_q == '0 && !err_q && $stable(pc_q)));
endmodule

// File: rtl/mbr_tree_sel.sv
module mbr_tree_sel
    import mbr_pkg::*;
#(
    parameter int unsigned NCC    = CC_BITS,
    parameter int unsigned NP     = MAX_PATHS,
    parameter int unsigned PC_W   = PC_BITS,
    parameter int unsigned SLOT_W = SLOT_BITS,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_i,
    input  logic                 stall_i,
    input  logic [NCC-1:0]       cc_i,
    input  logic [NP-1:0]        path_used_i,
    input  logic [NP*NCC-1:0]    care_i,
    input  logic [NP*NCC-1:0]    value_i,
    input  logic [NP*PC_W-1:0]   target_i,
    input  logic [NP*SLOT_W-1:0] commit_i,
    output logic [PC_W-1:0]      next_pc_o,
    output logic [SLOT_W-1:0]    commit_o,
    output logic                 err_o
);
    localparam int unsigned IDX_W = (NP > 1) ? $clog2(NP) : 1;

    logic [NP-1:0]     hit;
    logic [IDX_W-1:0]  sel;
    pick_e             status;
    logic [PC_W-1:0]   tgt_arr [NP];
    logic [SLOT_W-1:0] cmt_arr [NP];
    logic [PC_W-1:0]   sel_target;
    logic [SLOT_W-1:0] sel_commit;

    for (genvar p = 0; p < NP; p++) begin : g_path
        mbr_path_match #(.CC_W(NCC)) u_match (
            .cc    (cc_i),
            .care  (care_i [p*NCC +: NCC]),
            .value (value_i[p*NCC +: NCC]),
            .used  (path_used_i[p]),
            .hit   (hit[p])
        );
        assign tgt_arr[p] = target_i[p*PC_W +: PC_W];
        assign cmt_arr[p] = commit_i[p*SLOT_W +: SLOT_W];
    end

    mbr_path_pick #(.NP(NP), .IDX_W(IDX_W)) u_pick (
        .hit    (hit),
        .sel    (sel),
        .status (status)
    );

    always_comb begin
        sel_target = tgt_arr[sel];
        sel_commit = cmt_arr[sel];
    end

    mbr_out_reg #(.PC_W(PC_W), .SLOT_W(SLOT_W), .RESET_PC(RESET_PC)) u_out (
        .clk      (clk),
        .rst      (rst),
        .valid    (valid_i),
        .stall    (stall_i),
        .status   (status),
        .target   (sel_target),
        .commit   (sel_commit),
        .pc_q     (next_pc_o),
        .commit_q (commit_o),
        .err_q    (err_o)
    );

    // R6 R7
    bad_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !stall_i && !$onehot(hit)) |=>
            (err_o && next_pc_o == $past(target_i[PC_W-1:0])
                   && commit_o == $past(commit_i[SLOT_W-1:0])));

    // R3
    one_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !stall_i && $onehot(hit)) |=> !err_o);

    // R5
    unused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> ((hit & ~path_used_i) == '0));
endmodule

// File: tb/mbr_tree_sel_tb.sv
`timescale 1ns/1ps
module mbr_tree_sel_tb;
    localparam int NCC = 8, NP = 8, PC_W = 16, SW = 12;

    logic clk = 1'b0, rst = 1'b1, valid = 1'b0, stall = 1'b0;
    logic [NCC-1:0]    cc = '0;
    logic [NP-1:0]     used = '0;
    logic [NP*NCC-1:0] care = '0, value = '0;
    logic [NP*PC_W-1:0] tgt = '0;
    logic [NP*SW-1:0]  cmt = '0;
    logic [PC_W-1:0]   pc_o;
    logic [SW-1:0]     cm_o;
    logic              err_o;

    logic [PC_W-1:0] e_pc = '0;
    logic [SW-1:0]   e_cm = '0;
    logic            e_err = 1'b0;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    mbr_tree_sel u_dut (
        .clk(clk), .rst(rst), .valid_i(valid), .stall_i(stall), .cc_i(cc),
        .path_used_i(used), .care_i(care), .value_i(value), .target_i(tgt),
        .commit_i(cmt), .next_pc_o(pc_o), .commit_o(cm_o), .err_o(err_o));

    function automatic int count_hits(output int w);
        int n = 0;
        w = 0;
        for (int p = 0; p < NP; p++)
            if (used[p] && (((cc ^ value[p*NCC +: NCC]) & care[p*NCC +: NCC]) == '0)) begin
                n++; w = p;
            end
        return n;
    endfunction

    task automatic predict();
        int w, n;
        n = count_hits(w);
        if (stall) return;
        if (!valid) begin e_cm = '0; e_err = 1'b0; return; end
        if (n != 1) w = 0;
        e_pc = tgt[w*PC_W +: PC_W];
        e_cm = cmt[w*SW +: SW];
        e_err = (n != 1);
    endtask

    task automatic check(string req);
        n_chk++;
        if (pc_o !== e_pc || cm_o !== e_cm || err_o !== e_err) begin
            n_bad++;
            $display("FAIL %s: pc=%h commit=%h err=%b expected pc=%h commit=%h err=%b",
                     req, pc_o, cm_o, err_o, e_pc, e_cm, e_err);
        end
    endtask

    // inputs already set (after a negedge); clock one edge, then compare
    task automatic step(string req);
        predict();
        @(posedge clk); #1;
        check(req);
        @(negedge clk);
    endtask

    task automatic rand_payload();
        for (int p = 0; p < NP; p++) begin
            tgt[p*PC_W +: PC_W] = PC_W'($urandom);
            cmt[p*SW +: SW]     = SW'($urandom);
        end
    endtask

    // builds a tree in which only path win matches cc
    task automatic one_winner(int win, logic win_uncond);
        logic [NCC-1:0] c, v;
        int b;
        used = '1;
        for (int p = 0; p < NP; p++) begin
            c = NCC'($urandom);
            v = NCC'($urandom);
            if (p == win) begin
                if (win_uncond) c = '0;
                v = (v & ~c) | (cc & c);
            end else begin
                b = $urandom_range(NCC-1, 0);
                c[b] = 1'b1;
                v[b] = ~cc[b];
            end
            care[p*NCC +: NCC]  = c;
            value[p*NCC +: NCC] = v;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        rand_payload();
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset state");
        @(negedge clk);
        rst = 1'b0;
        valid = 1'b1;

        // R3 R2 R10: random single-winner trees back to back
        for (int i = 0; i < 60; i++) begin
            cc = NCC'($urandom);
            rand_payload();
            one_winner(i % NP, 1'b0);
            step((i % 2) ? "R3 single match" : "R10 back-to-back R2");
        end

        // R4: unconditional path at an interior position, every cc
        for (int i = 0; i < 8; i++) begin
            cc = NCC'($urandom);
            one_winner(3, 1'b1);
            step("R4 unconditional path");
        end

        // R5: path 5 is unused though its masks would match; path 2 wins
        cc = 8'hA5;
        one_winner(2, 1'b0);
        care[5*NCC +: NCC] = '0;
        used[5] = 1'b0;
        step("R5 unused path ignored");
        used = '0;
        step("R5 all paths unused");

        // R6: nothing matches
        cc = 8'h3C;
        one_winner(6, 1'b0);
        care[6*NCC +: NCC] = 8'h01;
        value[6*NCC +: NCC] = 8'h01;
        step("R6 no match");

        // R7: two matches
        cc = 8'hF0;
        one_winner(4, 1'b0);
        care[7*NCC +: NCC] = '0;
        step("R7 double match");
        one_winner(0, 1'b0);
        care[1*NCC +: NCC] = 8'h80;
        value[1*NCC +: NCC] = 8'h80;
        step("R7 double match incl path 0");

        // R8: stall holds while inputs change
        cc = 8'h11;
        one_winner(5, 1'b0);
        step("R3 before stall");
        stall = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cc = NCC'($urandom);
            rand_payload();
            one_winner(i, 1'b0);
            step("R8 stall hold");
        end
        stall = 1'b0;
        step("R8 release");

        // R9: idle cycle after an error
        cc = 8'h00;
        used = '0;
        step("R6 before idle");
        valid = 1'b0;
        rand_payload();
        step("R9 idle clears");
        step("R9 idle stays");
        valid = 1'b1;
        cc = 8'h5A;
        one_winner(7, 1'b0);
        step("R10 resume");

        // R1: reset again mid-run
        rst = 1'b1;
        @(posedge clk); #1;
        e_pc = '0; e_cm = '0; e_err = 1'b0;
        check("R1 re-reset");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule